// File: doc/BRIEF.md
# Control/Bulk List Service Arbiter

This block sits in a USB host controller's list-processing engine. It picks, once per service slot inside each 1 ms frame, whether the next non-periodic endpoint comes from the control list or the bulk list. Each list has an enable bit, a "list filled" flag and a "current pointer is null" indication. A list is eligible only when all three agree. Software sets the filled flag after it queues new transfers. The arbiter clears the flag at the moment it grants that list.

When both lists are eligible, a 2-bit ratio field decides the share. A value of N gives N+1 control services for every bulk service. The ratio count restarts at every frame start, so each frame opens with control traffic. A grant stays up until the service engine returns a one-cycle done pulse. While the frame is close to its end, no new grant is started. When nothing can be served, the block shows idle.

Top module: `np_list_arbiter`

## Requirements
- R1: After reset both grants are low, `idle` is high, both filled flags read 0 and the ratio count is zero.
- R2: With both lists eligible, grants follow the pattern of (`ratio`+1) control grants and then one bulk grant, repeating; `ratio`=0 gives alternation and `ratio`=3 gives four control grants per bulk grant.
- R3: The enable bits are sampled only in a cycle with `frame_start` high. Clearing or setting an enable bit mid-frame changes nothing until the next frame start.
- R4: A list whose current pointer is null is eligible only while its filled flag reads 1. A list with a non-null pointer is eligible whenever it is enabled for the frame.
- R5: The filled flag of a list reads 0 from the cycle in which that list's grant rises. A set pulse in the same cycle as the grant wins, leaving the flag at 1.
- R6: When only one list is eligible, that list is granted back to back regardless of the ratio count.
- R7: A frame start clears the ratio count, so the first grant after it goes to control when both lists are eligible.
- R8: At most one grant is high at a time. A grant stays high until a cycle with `svc_done` high, and it is low in the cycle after that pulse. A new grant rises no earlier than one cycle later.
- R9: While `frame_end_near` is high, no new grant rises; a grant already high is held. No grant rises in a cycle that follows a `frame_start` edge.
- R10: `idle` is high exactly when no grant is high and neither list was eligible in the cycle before. It is low while an eligible list is held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| frame_end_near | input | 1 | High when too little frame time remains to start a service |
| ratio | input | RATIO_W | Control-to-bulk ratio, value N means N+1 control per bulk |
| ctl_en | input | 1 | Control list enable |
| blk_en | input | 1 | Bulk list enable |
| ctl_fill_set | input | 1 | Pulse from software: control list has new work |
| blk_fill_set | input | 1 | Pulse from software: bulk list has new work |
| ctl_ptr_null | input | 1 | Control current pointer is null |
| blk_ptr_null | input | 1 | Bulk current pointer is null |
| svc_done | input | 1 | One-cycle pulse: granted endpoint service finished |
| grant_ctl | output | 1 | Control list granted |
| grant_blk | output | 1 | Bulk list granted |
| idle | output | 1 | No grant and no eligible list |
| ctl_filled | output | 1 | Control list filled flag |
| blk_filled | output | 1 | Bulk list filled flag |

## Verification
A corrupted ratio count shows as a wrong list in the grant sequence. It appears within at most five grants of steady traffic, or on the very first grant after a frame start. A stale per-frame enable or a filled flag stuck at 1 shows as a grant to a list that should be silent, or as a wrong `ctl_filled`/`blk_filled` value in the same cycle that a grant rises. A broken hold/issue state shows at once as two grants together, a grant dropping without a done pulse, or a grant rising while the frame-end window is open.

// File: rtl/np_arb_pkg.sv
package np_arb_pkg;
  localparam int NLIST    = 2;
  localparam int LIST_CTL = 0;
  localparam int LIST_BLK = 1;

  typedef enum logic {
    ST_ARB  = 1'b0,
    ST_BUSY = 1'b1
  } arb_state_t;
endpackage

// File: rtl/np_list_state.sv
module np_list_state (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic en,
  input  logic fill_set,
  input  logic ptr_null,
  input  logic take,
  output logic filled,
  output logic eligible
);
  logic frame_en_q;
  logic filled_q;

  // enable only takes effect at a frame boundary
  always_ff @(posedge clk) begin
    if (rst)              frame_en_q <= 1'b0;
    else if (frame_start) frame_en_q <= en;
  end

  // software set has priority over the clear on grant
  always_ff @(posedge clk) begin
    if (rst)           filled_q <= 1'b0;
    else if (fill_set) filled_q <= 1'b1;
    else if (take)     filled_q <= 1'b0;
  end

  assign filled   = filled_q;
  assign eligible = frame_en_q && (!ptr_null || filled_q);
endmodule

// File: rtl/np_ratio_ctr.sv
module np_ratio_ctr #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ctl_taken,
  input  logic               blk_taken,
  output logic               prefer_ctl
);
  localparam int CNT_W = RATIO_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << RATIO_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      cnt_q <= '0;
    end else if (blk_taken) begin
      cnt_q <= '0;
    end else if (ctl_taken && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign prefer_ctl = (cnt_q <= {1'b0, ratio});
endmodule

// File: rtl/np_grant_fsm.sv
module np_grant_fsm
  import np_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             frame_end_near,
  input  logic [NLIST-1:0] eligible,
  input  logic             prefer_ctl,
  input  logic             svc_done,
  output logic [NLIST-1:0] take,
  output logic [NLIST-1:0] grant,
  output logic             idle
);
  arb_state_t       state_q;
  logic [NLIST-1:0] gnt_q;
  logic [NLIST-1:0] gnt_d;
  logic             idle_q;

  always_comb begin
    take = '0;
    if (state_q == ST_ARB && !frame_start && !frame_end_near) begin
      if (eligible[LIST_CTL] && (prefer_ctl || !eligible[LIST_BLK]))
        take[LIST_CTL] = 1'b1;
      else if (eligible[LIST_BLK])
        take[LIST_BLK] = 1'b1;
    end
  end

  always_comb begin
    if (state_q == ST_BUSY) gnt_d = svc_done ? '0 : gnt_q;
    else                    gnt_d = take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ARB;
      gnt_q   <= '0;
      idle_q  <= 1'b1;
    end else begin
      state_q <= (gnt_d != '0) ? ST_BUSY : ST_ARB;
      gnt_q   <= gnt_d;
      idle_q  <= (gnt_d == '0) && (eligible == '0);
    end
  end

  assign grant = gnt_q;
  assign idle  = idle_q;
endmodule

// File: rtl/np_list_arbiter.sv
module np_list_arbiter
  import np_arb_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic               frame_end_near,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ctl_en,
  input  logic               blk_en,
  input  logic               ctl_fill_set,
  input  logic               blk_fill_set,
  input  logic               ctl_ptr_null,
  input  logic               blk_ptr_null,
  input  logic               svc_done,
  output logic               grant_ctl,
  output logic               grant_blk,
  output logic               idle,
  output logic               ctl_filled,
  output logic               blk_filled
);
  logic [NLIST-1:0] en_v, set_v, null_v, take_v, elig_v, filled_v, gnt_v;
  logic             prefer_ctl;

  assign en_v[LIST_CTL]   = ctl_en;
  assign en_v[LIST_BLK]   = blk_en;
  assign set_v[LIST_CTL]  = ctl_fill_set;
  assign set_v[LIST_BLK]  = blk_fill_set;
  assign null_v[LIST_CTL] = ctl_ptr_null;
  assign null_v[LIST_BLK] = blk_ptr_null;

  for (genvar g = 0; g < NLIST; g++) begin : g_list
    np_list_state u_ls (
      .clk         (clk),
      .rst         (rst),
      .frame_start (frame_start),
      .en          (en_v[g]),
      .fill_set    (set_v[g]),
      .ptr_null    (null_v[g]),
      .take        (take_v[g]),
      .filled      (filled_v[g]),
      .eligible    (elig_v[g])
    );
  end

  np_ratio_ctr #(.RATIO_W(RATIO_W)) u_ratio (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .ratio       (ratio),
    .ctl_taken   (take_v[LIST_CTL]),
    .blk_taken   (take_v[LIST_BLK]),
    .prefer_ctl  (prefer_ctl)
  );

  np_grant_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .frame_start    (frame_start),
    .frame_end_near (frame_end_near),
    .eligible       (elig_v),
    .prefer_ctl     (prefer_ctl),
    .svc_done       (svc_done),
    .take           (take_v),
    .grant          (gnt_v),
    .idle           (idle)
  );

  assign grant_ctl  = gnt_v[LIST_CTL];
  assign grant_blk  = gnt_v[LIST_BLK];
  assign ctl_filled = filled_v[LIST_CTL];
  assign blk_filled = filled_v[LIST_BLK];
endmodule

// File: rtl/np_arb_checker.sv
module np_arb_checker (
  input logic clk,
  input logic rst,
  input logic frame_start,
  input logic frame_end_near,
  input logic ctl_fill_set,
  input logic blk_fill_set,
  input logic svc_done,
  input logic grant_ctl,
  input logic grant_blk,
  input logic idle,
  input logic ctl_filled,
  input logic blk_filled
);
  logic any_g;
  assign any_g = grant_ctl || grant_blk;

  p_one_grant_r8: assert property (@(posedge clk) disable iff (rst)
    !(grant_ctl && grant_blk));

  p_hold_ctl_r8: assert property (@(posedge clk) disable iff (rst)
    grant_ctl && !svc_done |=> grant_ctl);

  p_hold_blk_r8: assert property (@(posedge clk) disable iff (rst)
    grant_blk && !svc_done |=> grant_blk);

  p_drop_on_done_r8: assert property (@(posedge clk) disable iff (rst)
    any_g && svc_done |=> !any_g);

  p_no_start_near_end_r9: assert property (@(posedge clk) disable iff (rst)
    !any_g && frame_end_near |=> !any_g);

  p_no_start_on_frame_r9: assert property (@(posedge clk) disable iff (rst)
    !any_g && frame_start |=> !any_g);

  p_idle_no_grant_r10: assert property (@(posedge clk) disable iff (rst)
    idle |-> !any_g);

  p_ctl_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_ctl) && !$past(ctl_fill_set) |-> !ctl_filled);

  p_blk_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_blk) && !$past(blk_fill_set) |-> !blk_filled);
endmodule

bind np_list_arbiter np_arb_checker u_chk (
  .clk            (clk),
  .rst            (rst),
  .frame_start    (frame_start),
  .frame_end_near (frame_end_near),
  .ctl_fill_set   (ctl_fill_set),
  .blk_fill_set   (blk_fill_set),
  .svc_done       (svc_done),
  .grant_ctl      (grant_ctl),
  .grant_blk      (grant_blk),
  .idle           (idle),
  .ctl_filled     (ctl_filled),
  .blk_filled     (blk_filled)
);

// File: tb/sim_np_list_arbiter.sv
`timescale 1ns/1ps
module sim_np_list_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 0, frame_end_near = 0;
  logic [1:0] ratio = 0;
  logic       ctl_en = 0, blk_en = 0, ctl_fill_set = 0, blk_fill_set = 0;
  logic       ctl_ptr_null = 0, blk_ptr_null = 0, svc_done = 0;
  logic       grant_ctl, grant_blk, idle, ctl_filled, blk_filled;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  np_list_arbiter #(.RATIO_W(2)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end_near(frame_end_near),
    .ratio(ratio), .ctl_en(ctl_en), .blk_en(blk_en), .ctl_fill_set(ctl_fill_set),
    .blk_fill_set(blk_fill_set), .ctl_ptr_null(ctl_ptr_null), .blk_ptr_null(blk_ptr_null),
    .svc_done(svc_done), .grant_ctl(grant_ctl), .grant_blk(grant_blk), .idle(idle),
    .ctl_filled(ctl_filled), .blk_filled(blk_filled)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_frame();
    frame_start = 1; tick(); frame_start = 0;
  endtask

  task automatic pulse_done();
    svc_done = 1; tick(); svc_done = 0;
  endtask

  // 0 none, 1 control, 2 bulk
  task automatic wait_grant(output int who);
    who = 0;
    for (int i = 0; i < 20; i++) begin
      if (grant_ctl) begin who = 1; break; end
      if (grant_blk) begin who = 2; break; end
      tick();
    end
  endtask

  task automatic quiesce();
    ctl_en = 0; blk_en = 0; ctl_ptr_null = 0; blk_ptr_null = 0; frame_end_near = 0;
    pulse_frame();
    for (int i = 0; i < 10; i++) begin
      if (grant_ctl || grant_blk) pulse_done(); else tick();
    end
  endtask

  task automatic t_reset();
    chk("R1", "grant_ctl", grant_ctl, 0);
    chk("R1", "grant_blk", grant_blk, 0);
    chk("R1", "idle", idle, 1);
    chk("R1", "ctl_filled", ctl_filled, 0);
    chk("R1", "blk_filled", blk_filled, 0);
  endtask

  task automatic t_ratio(input int n);
    int who;
    quiesce();
    ratio = 2'(n); ctl_en = 1; blk_en = 1;
    pulse_frame();
    for (int k = 0; k < 2 * (n + 2); k++) begin
      wait_grant(who);
      chk("R2", $sformatf("ratio %0d grant %0d", n, k), who, ((k % (n + 2)) < n + 1) ? 1 : 2);
      pulse_done();
      chk("R8", "grant low after done", int'(grant_ctl || grant_blk), 0);
    end
  endtask

  task automatic t_conserve();
    int who;
    quiesce();
    ratio = 2'd3; ctl_en = 1; blk_en = 1; ctl_ptr_null = 1;
    pulse_frame();
    for (int k = 0; k < 3; k++) begin
      wait_grant(who);
      chk("R6", "bulk back to back", who, 2);
      pulse_done();
    end
    quiesce();
    ratio = 2'd0; ctl_en = 1; blk_en = 1; blk_ptr_null = 1;
    pulse_frame();
    for (int k = 0; k < 3; k++) begin
      wait_grant(who);
      chk("R6", "control back to back", who, 1);
      pulse_done();
    end
  endtask

  task automatic t_frame_reset();
    int who;
    quiesce();
    ratio = 2'd0; ctl_en = 1; blk_en = 1;
    pulse_frame();
    wait_grant(who);
    chk("R7", "first grant of frame", who, 1);
    frame_end_near = 1;
    pulse_done();
    for (int i = 0; i < 4; i++) tick();
    chk("R9", "no grant near frame end", int'(grant_ctl || grant_blk), 0);
    chk("R10", "idle low while held back", idle, 0);
    pulse_frame();
    frame_end_near = 0;
    wait_grant(who);
    chk("R7", "count cleared at frame start", who, 1);
    frame_end_near = 1;
    for (int i = 0; i < 3; i++) tick();
    chk("R9", "existing grant held", grant_ctl, 1);
    frame_end_near = 0;
    pulse_done();
  endtask

  task automatic t_enable();
    int who;
    quiesce();
    ratio = 2'd0; ctl_en = 1; blk_en = 0;
    pulse_frame();
    wait_grant(who);
    chk("R3", "control granted", who, 1);
    ctl_en = 0; blk_en = 1;
    pulse_done();
    wait_grant(who);
    chk("R3", "mid-frame enable change ignored", who, 1);
    frame_end_near = 1;
    pulse_done();
    tick();
    pulse_frame();
    frame_end_near = 0;
    wait_grant(who);
    chk("R3", "new enables after frame start", who, 2);
    pulse_done();
  endtask

  task automatic t_null_filled();
    quiesce();
    ctl_en = 1; blk_en = 0; ctl_ptr_null = 1;
    pulse_frame();
    for (int i = 0; i < 3; i++) tick();
    chk("R4", "null pointer, not filled: no grant", grant_ctl, 0);
    chk("R10", "idle with nothing eligible", idle, 1);
    ctl_fill_set = 1; tick(); ctl_fill_set = 0;
    chk("R4", "filled flag set", ctl_filled, 1);
    tick();
    chk("R4", "null pointer but filled: granted", grant_ctl, 1);
    chk("R5", "filled cleared with grant", ctl_filled, 0);
    pulse_done();
    chk("R10", "idle right after done", idle, 1);
    tick();
    chk("R4", "no grant once flag cleared", grant_ctl, 0);
    ctl_ptr_null = 0; ctl_fill_set = 1; tick(); ctl_fill_set = 0;
    chk("R5", "grant on coincident set", grant_ctl, 1);
    chk("R5", "coincident set wins", ctl_filled, 1);
    pulse_done();
    tick();
    chk("R5", "next grant clears flag", ctl_filled, 0);
    chk("R5", "next grant up", grant_ctl, 1);
    pulse_done();
  endtask

  task automatic t_hold();
    int who;
    quiesce();
    ratio = 2'd1; ctl_en = 1; blk_en = 1;
    pulse_frame();
    wait_grant(who);
    for (int i = 0; i < 5; i++) tick();
    chk("R8", "grant held without done", grant_ctl, 1);
    chk("R8", "other grant low", grant_blk, 0);
    pulse_done();
    chk("R8", "grant low after done", int'(grant_ctl || grant_blk), 0);
    tick();
    chk("R8", "next grant one cycle later", grant_ctl, 1);
    pulse_done();
  endtask

  initial begin
    #2;
    tick(); tick();
    rst = 0;
    tick();
    t_reset();
    for (int n = 0; n < 4; n++) t_ratio(n);
    t_conserve();
    t_frame_reset();
    t_enable();
    t_null_filled();
    t_hold();
    quiesce();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule